// File: doc/BRIEF.md
# Gated I/O BAR Decoder

This block implements a PCI-style I/O base address register together with a decoder that claims I/O cycles. It targets a small window in a 16-bit I/O address space. Configuration software writes the base through a dword-indexed configuration port, with one write strobe per byte. Bits 15:6 of the register are programmable, so the base sits on a 64-byte boundary. Only the first 8 bytes above that base are decoded.

Each I/O cycle arrives as a valid strobe, an address and a size code. The block raises its claim output one clock later when three conditions all hold. First, the whole access lies inside the 8-byte window. Second, the function is in power state D0 with I/O decoding enabled. Third, none of the device-off or fuse disable inputs is active. VGA state plays no part in the claim. The block also does not multiplex the rest of configuration space.

Top module: `iobar_decoder`

## Requirements
- R1: After reset, a read at dword index 8 (byte offset 0x20) returns 0x00000001.
- R2: A write at dword index 8 loads register bits 15:6 from the write data. Byte strobe 0 controls bits 7:6 and byte strobe 1 controls bits 15:8. A bit whose byte strobe is low keeps its value.
- R3: At index 8, bits 31:16 and 5:3 always read 0, bits 2:1 always read 00 and bit 0 always reads 1, whatever data is written.
- R4: A read at any other dword index returns 0. A write at any other index leaves the base unchanged.
- R5: An address lies in the window when its bits 15:6 equal the base field and its bits 5:3 are zero. The window is 8 bytes long.
- R6: Size code 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 is reserved. A cycle is claimed only if its last byte (start address + size − 1) also lies in the window. Size code 3 is never claimed.
- R7: A cycle is claimed only when the power state is D0 (code 0; codes 1 to 3 are D1 to D3) and the I/O enable input is 1.
- R8: No cycle is claimed while the device-off input, the fuse-disable input or the fuse-override-disable input is 1.
- R9: The claim output is registered. It reflects the cycle presented one clock earlier and is 0 after any clock at which no valid cycle was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte strobes for the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for the addressed dword (combinational) |
| io_valid | input | 1 | I/O cycle present |
| io_addr | input | 16 | I/O start address |
| io_size | input | 2 | I/O size code |
| pm_state | input | 2 | Power state, 0 = D0 |
| io_en | input | 1 | Command-register I/O enable |
| dev_off | input | 1 | Device turned off |
| fuse_dis | input | 1 | Fuse disable |
| fuse_ovr_dis | input | 1 | Fuse-override disable |
| io_claim | output | 1 | Registered claim for the previous cycle |

## Verification
The assertions assume that the power-state code, the enables and the disables are steady across the clock edge that samples an I/O cycle. They also assume that configuration writes and I/O cycles are synchronous to the same clock. The bench changes every input only on the falling edge, so each cycle's inputs are settled for one full rising edge. It applies configuration writes only between I/O sequences and waits for all pending claims to drain first. This way the base seen by each decoded cycle is the one the bench model holds.

// File: rtl/iobar_pkg.sv
package iobar_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } io_size_e;

  localparam logic [1:0] PM_D0 = 2'd0;

  // Number of bytes moved by a size code; zero marks the reserved code.
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE:  return 1;
      SZ_WORD:  return 2;
      SZ_DWORD: return 4;
      default:  return 0;
    endcase
  endfunction

  // True when an access of nbytes starting at window offset off ends inside the window.
  function automatic logic span_fits(input int unsigned off,
                                     input int unsigned nbytes,
                                     input int unsigned win_bytes);
    return (nbytes != 0) && ((off + nbytes) <= win_bytes);
  endfunction

endpackage

// File: rtl/iobar_reg.sv
module iobar_reg #(
  parameter int IO_AW      = 16,
  parameter int ALIGN_LOG2 = 6,
  parameter int IDX_W      = 6,
  parameter int BAR_IDX    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic [IO_AW-ALIGN_LOG2-1:0] base_o
);
  localparam int BASE_W = IO_AW - ALIGN_LOG2;

  logic              bar_hit;
  logic              bar_write;
  logic [BASE_W-1:0] wr_mask;
  logic [BASE_W-1:0] wr_field;
  logic [BASE_W-1:0] base_q;

  assign bar_hit   = (cfg_idx == IDX_W'(BAR_IDX));
  assign bar_write = cfg_wr && bar_hit;
  assign wr_field  = cfg_wdata[IO_AW-1:ALIGN_LOG2];

  // Per-bit write mask taken from the byte strobe covering that bit.
  for (genvar b = 0; b < BASE_W; b++) begin : g_mask
    localparam int POS = b + ALIGN_LOG2;
    assign wr_mask[b] = bar_write && cfg_be[POS/8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= (base_q & ~wr_mask) | (wr_field & wr_mask);
  end

  always_comb begin
    cfg_rdata = '0;
    if (bar_hit) begin
      cfg_rdata[IO_AW-1:ALIGN_LOG2] = base_q;
      cfg_rdata[0] = 1'b1;
    end
  end

  assign base_o = base_q;

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[31:IO_AW], cfg_wdata[ALIGN_LOG2-1:0], cfg_be[3:2]};

  // R4 / R2: base only moves on a write addressed to this register
  a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bar_write |=> $stable(base_o));

  // R1: base reads as zero right after reset
  a_r1_reset_base: assert property (@(posedge clk)
    !rst_n |=> (base_o == '0));

endmodule

// File: rtl/iobar_gate.sv
module iobar_gate (
  input  logic [1:0] pm_state,
  input  logic       io_en,
  input  logic       dev_off,
  input  logic       fuse_dis,
  input  logic       fuse_ovr_dis,
  output logic       permit
);
  import iobar_pkg::*;

  logic in_d0;
  logic any_disable;

  assign in_d0       = (pm_state == PM_D0);
  assign any_disable = dev_off | fuse_dis | fuse_ovr_dis;
  assign permit      = in_d0 && io_en && !any_disable;

endmodule

// File: rtl/iobar_window.sv
module iobar_window #(
  parameter int IO_AW      = 16,
  parameter int ALIGN_LOG2 = 6,
  parameter int WIN_LOG2   = 3
) (
  input  logic [IO_AW-1:0]            addr,
  input  logic [1:0]                  size,
  input  logic [IO_AW-ALIGN_LOG2-1:0] base,
  output logic                        hit
);
  import iobar_pkg::*;

  localparam int WIN_BYTES = 1 << WIN_LOG2;

  logic        base_match;
  logic        pad_zero;
  logic        fits;
  int unsigned off;

  assign base_match = (addr[IO_AW-1:ALIGN_LOG2] == base);
  assign pad_zero   = (addr[ALIGN_LOG2-1:WIN_LOG2] == '0);
  assign off        = int'(addr[WIN_LOG2-1:0]);
  assign fits       = span_fits(off, size_bytes(size), WIN_BYTES);
  assign hit        = base_match && pad_zero && fits;

endmodule

// File: rtl/iobar_decoder.sv
module iobar_decoder #(
  parameter int IO_AW      = 16,
  parameter int ALIGN_LOG2 = 6,
  parameter int WIN_LOG2   = 3,
  parameter int IDX_W      = 6,
  parameter int BAR_IDX    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             io_valid,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [1:0]       pm_state,
  input  logic             io_en,
  input  logic             dev_off,
  input  logic             fuse_dis,
  input  logic             fuse_ovr_dis,
  output logic             io_claim
);
  localparam int BASE_W = IO_AW - ALIGN_LOG2;

  logic [BASE_W-1:0] base;
  logic              permit;
  logic              win_hit;
  logic              claim_q;

  iobar_reg #(.IO_AW(IO_AW), .ALIGN_LOG2(ALIGN_LOG2), .IDX_W(IDX_W), .BAR_IDX(BAR_IDX)) u_reg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .base_o(base)
  );

  iobar_gate u_gate (
    .pm_state(pm_state), .io_en(io_en), .dev_off(dev_off),
    .fuse_dis(fuse_dis), .fuse_ovr_dis(fuse_ovr_dis), .permit(permit)
  );

  iobar_window #(.IO_AW(IO_AW), .ALIGN_LOG2(ALIGN_LOG2), .WIN_LOG2(WIN_LOG2)) u_win (
    .addr(io_addr), .size(io_size), .base(base), .hit(win_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) claim_q <= 1'b0;
    else        claim_q <= io_valid && permit && win_hit;
  end

  assign io_claim = claim_q;

  // R9: no valid cycle, no claim on the next clock
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |=> !io_claim);

  // R7: claim needs D0 and I/O enable in the cycle before
  a_r7_needs_d0_en: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state != 2'd0 || !io_en) |=> !io_claim);

  // R8: any disable input blocks the claim
  a_r8_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_off || fuse_dis || fuse_ovr_dis) |=> !io_claim);

  // R5: a claim only follows a window hit
  a_r5_claim_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |=> !io_claim);

  // R6: reserved size never claimed
  a_r6_rsvd_size: assert property (@(posedge clk) disable iff (!rst_n)
    (io_size == 2'd3) |=> !io_claim);

endmodule

// File: tb/tb_iobar_decoder.sv
`timescale 1ns/1ps
module tb_iobar_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        io_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [1:0]  pm_state = '0;
  logic        io_en = 1'b1;
  logic        dev_off = 1'b0;
  logic        fuse_dis = 1'b0;
  logic        fuse_ovr_dis = 1'b0;
  logic        io_claim;

  int vectors = 0;
  int fails = 0;
  logic [9:0] base_model = '0;

  typedef struct { logic exp; string tag; logic [15:0] addr; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  iobar_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid), .io_addr(io_addr),
    .io_size(io_size), .pm_state(pm_state), .io_en(io_en), .dev_off(dev_off),
    .fuse_dis(fuse_dis), .fuse_ovr_dis(fuse_ovr_dis), .io_claim(io_claim)
  );

  function automatic logic model_claim(input logic v, input logic [15:0] a, input logic [1:0] s);
    int lo, hi, wlo, n;
    if (!v || s == 2'd3) return 1'b0;
    if (pm_state != 2'd0 || !io_en || dev_off || fuse_dis || fuse_ovr_dis) return 1'b0;
    n   = 1 << s;
    lo  = int'(a);
    hi  = lo + n - 1;
    wlo = int'(base_model) * 64;
    return (lo >= wlo) && (hi <= wlo + 7);
  endfunction

  task automatic io_cyc(input logic v, input logic [15:0] a, input logic [1:0] s, input string tag);
    item_t it;
    @(negedge clk);
    io_valid = v; io_addr = a; io_size = s;
    it.exp = model_claim(v, a, s); it.tag = tag; it.addr = a;
    sb.push_back(it);
  endtask

  task automatic drain();
    io_cyc(1'b0, 16'h0000, 2'd0, "R9");
    while (sb.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare registered claim shortly after each rising edge
  always @(posedge clk) begin
    #5;
    if (sb.size() != 0) begin
      item_t it;
      it = sb.pop_front();
      vectors++;
      if (io_claim !== it.exp) begin
        fails++;
        $display("FAIL %s claim addr=%h actual=%b expected=%b", it.tag, it.addr, io_claim, it.exp);
      end
    end
  end

  task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    if (idx == 6'd8) begin
      if (be[0]) base_model[1:0] = d[7:6];
      if (be[1]) base_model[9:2] = d[15:8];
    end
  endtask

  task automatic cfg_check(input logic [5:0] idx, input logic [31:0] exp, input string tag);
    cfg_idx = idx;
    #1;
    vectors++;
    if (cfg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read idx=%0d actual=%h expected=%h", tag, idx, cfg_rdata, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset value
    cfg_check(6'd8, 32'h0000_0001, "R1");
    // R4 other index reads zero
    cfg_check(6'd9, 32'h0, "R4");
    cfg_check(6'd0, 32'h0, "R4");
    // R9 idle after reset
    io_cyc(1'b0, 16'h0000, 2'd0, "R9");
    drain();

    // R2 / R3 full write of ones
    cfg_write(6'd8, 4'hF, 32'hFFFF_FFFF);
    cfg_check(6'd8, 32'h0000_FFC1, "R3");
    // R4 write to other index has no effect
    cfg_write(6'd7, 4'hF, 32'h0000_0000);
    cfg_write(6'd9, 4'hF, 32'h0000_0000);
    cfg_check(6'd8, 32'h0000_FFC1, "R4");
    // R2 byte strobes
    cfg_write(6'd8, 4'b0001, 32'h0000_0000);
    cfg_check(6'd8, 32'h0000_FF01, "R2");
    cfg_write(6'd8, 4'b0010, 32'hFFFF_12FF);
    cfg_check(6'd8, 32'h0000_1201, "R2");

    // Window at 0x1200, all permitted
    io_cyc(1'b1, 16'h1200, 2'd0, "R5");
    io_cyc(1'b1, 16'h1207, 2'd0, "R5");
    io_cyc(1'b1, 16'h1208, 2'd0, "R5");
    io_cyc(1'b1, 16'h1238, 2'd0, "R5");
    io_cyc(1'b1, 16'h1240, 2'd0, "R5");
    io_cyc(1'b1, 16'h1300, 2'd0, "R5");
    io_cyc(1'b1, 16'h11FF, 2'd0, "R5");
    io_cyc(1'b1, 16'h1206, 2'd1, "R6");
    io_cyc(1'b1, 16'h1207, 2'd1, "R6");
    io_cyc(1'b1, 16'h1204, 2'd2, "R6");
    io_cyc(1'b1, 16'h1205, 2'd2, "R6");
    io_cyc(1'b1, 16'h1200, 2'd3, "R6");
    io_cyc(1'b0, 16'h1200, 2'd0, "R9");
    io_cyc(1'b1, 16'h1201, 2'd0, "R9");
    drain();

    // R7 power states and enable
    for (int p = 1; p < 4; p++) begin
      pm_state = 2'(p);
      io_cyc(1'b1, 16'h1200, 2'd0, "R7");
      drain();
    end
    pm_state = 2'd0;
    io_en = 1'b0;
    io_cyc(1'b1, 16'h1200, 2'd0, "R7");
    drain();
    io_en = 1'b1;
    // R8 disables
    dev_off = 1'b1;
    io_cyc(1'b1, 16'h1202, 2'd1, "R8");
    drain();
    dev_off = 1'b0; fuse_dis = 1'b1;
    io_cyc(1'b1, 16'h1202, 2'd1, "R8");
    drain();
    fuse_dis = 1'b0; fuse_ovr_dis = 1'b1;
    io_cyc(1'b1, 16'h1202, 2'd1, "R8");
    drain();
    fuse_ovr_dis = 1'b0;
    io_cyc(1'b1, 16'h1202, 2'd1, "R8");
    drain();

    // Window at top of space
    cfg_write(6'd8, 4'b0011, 32'h0000_FFC0);
    cfg_check(6'd8, 32'h0000_FFC1, "R2");
    io_cyc(1'b1, 16'hFFC4, 2'd2, "R6");
    io_cyc(1'b1, 16'hFFC7, 2'd1, "R6");
    io_cyc(1'b1, 16'hFFC0, 2'd0, "R5");
    io_cyc(1'b1, 16'h1200, 2'd0, "R5");
    drain();

    // R1 reset returns register to default
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    base_model = '0;
    cfg_check(6'd8, 32'h0000_0001, "R1");
    io_cyc(1'b1, 16'h0003, 2'd0, "R5");
    io_cyc(1'b1, 16'h0008, 2'd0, "R5");
    drain();

    summary();
  end
endmodule